// File: doc/BRIEF.md
# Power-Up Operating Mode Sequencer

This block is the start-up controller of a wireless charging transmitter. It leaves reset, waits for the supply and analog bias to settle, and reads the strap pins once. Depending on those straps it then asks an EEPROM loader for register contents and asks the current-sense unit for an offset calibration, followed by a settling wait. Finally it either enters Drive Mode on its own or holds in Initial Mode until software writes a go bit.

On entry to Drive Mode it reports one of three drive modes and fires a one-cycle start pulse. It keeps a drive-enable output up for the bridge PWM.

- In automatic power control mode, drive is always enabled.
- In stand-alone mode, drive is always enabled.
- In host-controlled mode, drive-enable follows a software transmit bit.

Both waits are counted at 8 MHz by one shared down-counter. A divider parameter shortens them for simulation. The EEPROM transfer, the analog calibration and the PWM sit outside the block and are reached through request/done handshakes.

Top module: `startup_mode_seq`

## Requirements
- R1: While `stby_n` is low, `mode_o` is 0, `load_req`, `cal_req`, `drive_en` and `drive_start` are 0. Raising `stby_n` starts the sequence again from the power-up wait.
- R2: After `stby_n` rises, the block stays in Initial Mode with no request for exactly POR_N clock edges, where POR_N = max(1, POR_CYC / WAIT_DIV). The next step begins at edge POR_N.
- R3: If the latched `strap_ms` is 1, `load_req` rises at edge POR_N and stays high until `load_done` is sampled high. If `strap_ms` is 0, `load_req` never rises.
- R4: All straps (`strap_ms`, `strap_auto`, `strap_duty`, `strap_cal`) are captured at edge POR_N.
  - `duty_init` shows the captured `strap_duty`, with bit 0 for the lowest duty strap.
  - Later changes of the strap pins have no effect on the sequence or on `duty_init`.
- R5: If the latched `strap_cal` is 1, `cal_req` rises after the load step and stays high until `cal_done` is sampled high. A settling wait of exactly CAL_N = max(1, CAL_CYC / WAIT_DIV) edges follows. If `strap_cal` is 0, both are skipped. `load_req` and `cal_req` are never high together.
- R6: After the load and calibration steps, a nonzero latched duty strap enters Drive Mode at once. An all-zero duty strap holds Initial Mode until `reg_go` is sampled high, and Drive Mode begins on that edge.
- R7: The drive mode is encoded on `mode_o` as follows:
  - 0: Initial Mode.
  - 1: automatic power control, selected when the latched `strap_auto` is 1.
  - 2: stand-alone, selected when `strap_auto` is 0 and any duty strap is 1.
  - 3: host-controlled, selected when `strap_auto` is 0 and all duty straps are 0.
- R8: `drive_start` is high for exactly the first cycle in which `mode_o` is nonzero. In modes 1 and 2, `drive_en` is 1 from that cycle on.
- R9: In mode 3, `drive_en` follows `reg_tx_on` combinationally. `drive_en` is 0 whenever `mode_o` is 0.
- R10: Once nonzero, `mode_o` does not change until `stby_n` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 8 MHz reference clock |
| stby_n | input | 1 | Active-low standby; asynchronous reset of the whole sequencer |
| strap_ms | input | 1 | Strap: 1 requests an EEPROM register load |
| strap_auto | input | 1 | Strap: 1 selects automatic power control mode |
| strap_duty | input | 3 | Duty straps |
| strap_cal | input | 1 | Strap: 1 requests current-sense offset calibration |
| reg_go | input | 1 | Software go bit that releases the Initial Mode hold |
| reg_tx_on | input | 1 | Software transmit bit used in host-controlled mode |
| load_done | input | 1 | EEPROM loader finished |
| cal_done | input | 1 | Calibration finished |
| mode_o | output | 2 | Current operating mode (encoding in R7) |
| load_req | output | 1 | EEPROM load request, level |
| cal_req | output | 1 | Calibration request, level |
| duty_init | output | 3 | Duty straps captured at start-up |
| drive_en | output | 1 | Bridge drive enable |
| drive_start | output | 1 | One-cycle pulse on entry to Drive Mode |

## Verification
The sequence is exercised with each of the following strap combinations:
- load and calibration both off;
- load only;
- calibration only;
- both on.

The duty straps are run both zero and nonzero, and `strap_auto` both high and low. This separates the paths that skip a step from those that wait on a handshake, and the self-starting drive from the software-held one.

The cycle of each start pulse is predicted from the handshake delays and both wait lengths. An off-by-one in either counter therefore shows up as a timing mismatch, not merely as a wrong mode. The strap pins are scrambled right after capture to show that only the captured values steer the sequence. A standby pulse in the middle of a load proves the restart from the beginning.

// File: rtl/startup_seq_pkg.sv
`timescale 1ns/1ps
package startup_seq_pkg;

  typedef enum logic [1:0] {
    MODE_INIT = 2'd0,
    MODE_AUTO = 2'd1,
    MODE_SOLO = 2'd2,
    MODE_HOST = 2'd3
  } op_mode_e;

  typedef enum logic [2:0] {
    ST_POR,
    ST_LOAD,
    ST_CAL,
    ST_SETTLE,
    ST_HOLD,
    ST_DRIVE
  } seq_state_e;

  typedef struct packed {
    logic       ms;
    logic       auto_pc;
    logic [2:0] duty;
    logic       cal;
  } strap_t;

  // A wait length in clock edges after division, never below one edge.
  function automatic int unsigned scaled_wait(int unsigned cyc, int unsigned div);
    int unsigned q;
    q = cyc / div;
    return (q == 0) ? 1 : q;
  endfunction

  function automatic op_mode_e pick_mode(logic auto_pc, logic [2:0] duty);
    if (auto_pc)     return MODE_AUTO;
    else if (|duty)  return MODE_SOLO;
    else             return MODE_HOST;
  endfunction

endpackage

// File: rtl/seq_wait_timer.sv
`timescale 1ns/1ps
module seq_wait_timer #(
  parameter int unsigned CNT_W = 8,
  parameter logic [CNT_W-1:0] INIT_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cnt <= INIT_VAL;
    else if (load)      cnt <= load_val;
    else if (cnt != '0) cnt <= cnt - 1'b1;
  end

  assign expired = (cnt == '0);

  // Once run down, the counter rests at zero until reloaded.
  AST_TIMER_RESTS: assert property (@(posedge clk) disable iff (!rst_n)
    (expired && !load) |=> expired); // R2
endmodule

// File: rtl/seq_strap_latch.sv
`timescale 1ns/1ps
module seq_strap_latch
  import startup_seq_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   capture,
  input  strap_t pins,
  output strap_t q,
  output logic   captured
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q        <= '0;
      captured <= 1'b0;
    end else if (capture && !captured) begin
      q        <= pins;
      captured <= 1'b1;
    end
  end

  AST_STRAPS_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    captured |=> $stable(q)); // R4
endmodule

// File: rtl/startup_mode_seq.sv
`timescale 1ns/1ps
module startup_mode_seq
  import startup_seq_pkg::*;
#(
  parameter int unsigned POR_CYC  = 800000,
  parameter int unsigned CAL_CYC  = 3200000,
  parameter int unsigned WAIT_DIV = 1
) (
  input  logic       clk,
  input  logic       stby_n,
  input  logic       strap_ms,
  input  logic       strap_auto,
  input  logic [2:0] strap_duty,
  input  logic       strap_cal,
  input  logic       reg_go,
  input  logic       reg_tx_on,
  input  logic       load_done,
  input  logic       cal_done,
  output logic [1:0] mode_o,
  output logic       load_req,
  output logic       cal_req,
  output logic [2:0] duty_init,
  output logic       drive_en,
  output logic       drive_start
);
  localparam int unsigned POR_N  = scaled_wait(POR_CYC, WAIT_DIV);
  localparam int unsigned CAL_N  = scaled_wait(CAL_CYC, WAIT_DIV);
  localparam int unsigned MAX_N  = (POR_N > CAL_N) ? POR_N : CAL_N;
  localparam int unsigned CNT_W  = $clog2(MAX_N + 1);
  localparam logic [CNT_W-1:0] POR_LOAD = CNT_W'(POR_N - 1);
  localparam logic [CNT_W-1:0] CAL_LOAD = CNT_W'(CAL_N - 1);

  seq_state_e state, state_nx;
  op_mode_e   mode_q;
  strap_t     pins, strap_q, eff;
  logic       captured;
  logic       expired;
  logic       timer_load;

  // Named internal events
  logic por_done;
  logic enter_drive;

  assign pins = '{ms: strap_ms, auto_pc: strap_auto, duty: strap_duty, cal: strap_cal};

  seq_strap_latch u_latch (
    .clk      (clk),
    .rst_n    (stby_n),
    .capture  (por_done),
    .pins     (pins),
    .q        (strap_q),
    .captured (captured)
  );

  seq_wait_timer #(.CNT_W(CNT_W), .INIT_VAL(POR_LOAD)) u_timer (
    .clk      (clk),
    .rst_n    (stby_n),
    .load     (timer_load),
    .load_val (CAL_LOAD),
    .expired  (expired)
  );

  assign por_done   = (state == ST_POR) && expired;
  assign eff        = por_done ? pins : strap_q;
  assign timer_load = (state == ST_CAL) && cal_done;

  always_comb begin
    state_nx = state;
    unique case (state)
      ST_POR: if (expired) begin
        if (eff.ms)         state_nx = ST_LOAD;
        else if (eff.cal)   state_nx = ST_CAL;
        else if (|eff.duty) state_nx = ST_DRIVE;
        else                state_nx = ST_HOLD;
      end
      ST_LOAD: if (load_done) begin
        if (eff.cal)        state_nx = ST_CAL;
        else if (|eff.duty) state_nx = ST_DRIVE;
        else                state_nx = ST_HOLD;
      end
      ST_CAL:    if (cal_done) state_nx = ST_SETTLE;
      ST_SETTLE: if (expired)  state_nx = (|eff.duty) ? ST_DRIVE : ST_HOLD;
      ST_HOLD:   if (reg_go)   state_nx = ST_DRIVE;
      ST_DRIVE:                state_nx = ST_DRIVE;
      default:                 state_nx = ST_POR;
    endcase
  end

  assign enter_drive = (state != ST_DRIVE) && (state_nx == ST_DRIVE);

  always_ff @(posedge clk or negedge stby_n) begin
    if (!stby_n) begin
      state       <= ST_POR;
      mode_q      <= MODE_INIT;
      drive_start <= 1'b0;
    end else begin
      state       <= state_nx;
      drive_start <= enter_drive;
      if (enter_drive) mode_q <= pick_mode(eff.auto_pc, eff.duty);
    end
  end

  assign mode_o    = mode_q;
  assign load_req  = (state == ST_LOAD);
  assign cal_req   = (state == ST_CAL);
  assign duty_init = strap_q.duty;
  assign drive_en  = (mode_q == MODE_HOST) ? reg_tx_on : (mode_q != MODE_INIT);

  AST_ONE_REQUEST: assert property (@(posedge clk) disable iff (!stby_n)
    !(load_req && cal_req)); // R5
  AST_LOAD_HELD: assert property (@(posedge clk) disable iff (!stby_n)
    (load_req && !load_done) |=> load_req); // R3
  AST_LOAD_NEEDS_MS: assert property (@(posedge clk) disable iff (!stby_n)
    load_req |-> (captured && strap_q.ms)); // R3
  AST_CAL_HELD: assert property (@(posedge clk) disable iff (!stby_n)
    (cal_req && !cal_done) |=> cal_req); // R5
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!stby_n)
    drive_start |=> !drive_start); // R8
  AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!stby_n)
    (mode_o != MODE_INIT) |=> $stable(mode_o)); // R10
  AST_EN_NEEDS_MODE: assert property (@(posedge clk) disable iff (!stby_n)
    drive_en |-> (mode_o != MODE_INIT)); // R9
  AST_HOLD_NEEDS_GO: assert property (@(posedge clk) disable iff (!stby_n)
    (state == ST_HOLD && !reg_go) |=> (mode_o == MODE_INIT)); // R6
endmodule

// File: tb/test_startup_mode_seq.sv
`timescale 1ns/1ps
module test_startup_mode_seq;
  localparam int DIV = 40000;
  localparam int N   = 800000 / DIV;
  localparam int W   = 3200000 / DIV;

  logic       clk = 1'b0;
  logic       stby_n = 1'b0;
  logic       strap_ms = 0, strap_auto = 0, strap_cal = 0;
  logic [2:0] strap_duty = '0;
  logic       reg_go = 0, reg_tx_on = 0, load_done = 0, cal_done = 0;
  logic [1:0] mode_o;
  logic       load_req, cal_req, drive_en, drive_start;
  logic [2:0] duty_init;

  always #2.5 clk = ~clk;

  startup_mode_seq #(.POR_CYC(800000), .CAL_CYC(3200000), .WAIT_DIV(DIV)) i_startup_mode_seq (
    .clk(clk), .stby_n(stby_n), .strap_ms(strap_ms), .strap_auto(strap_auto),
    .strap_duty(strap_duty), .strap_cal(strap_cal), .reg_go(reg_go),
    .reg_tx_on(reg_tx_on), .load_done(load_done), .cal_done(cal_done),
    .mode_o(mode_o), .load_req(load_req), .cal_req(cal_req),
    .duty_init(duty_init), .drive_en(drive_en), .drive_start(drive_start)
  );

  int cyc;
  always @(posedge clk or negedge stby_n)
    if (!stby_n) cyc <= 0; else cyc <= cyc + 1;

  int n_chk = 0, n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  typedef struct { int at; int mode; } exp_t;
  exp_t expq[$];

  // Monitor: every start pulse is matched against the scoreboard queue.
  always @(negedge clk) begin
    exp_t e;
    if (stby_n === 1'b1 && drive_start === 1'b1) begin
      if (expq.size() == 0) chk(1'b0, "R8", "unexpected drive_start", cyc, -1);
      else begin
        e = expq.pop_front();
        chk(cyc == e.at, "R2", "drive_start cycle", cyc, e.at);
        chk(int'(mode_o) == e.mode, "R7", "mode at start", mode_o, e.mode);
      end
    end
  end

  task automatic wait_cyc(input int k);
    while (cyc < k) @(negedge clk);
  endtask

  task automatic run_case(input bit ms, input bit au, input logic [2:0] du,
                          input bit ca, input int L, input int C, input int G);
    int t, tt, em;
    stby_n = 0; strap_ms = ms; strap_auto = au; strap_duty = du; strap_cal = ca;
    reg_go = 0; reg_tx_on = 0; load_done = 0; cal_done = 0;
    repeat (3) @(negedge clk);
    t = N;
    if (ms) t += L + 1;
    if (ca) t += C + 1 + W;
    if (du == 3'b000) t += G + 1;
    em = au ? 1 : ((du != 3'b000) ? 2 : 3);
    expq.push_back('{at: t, mode: em});
    stby_n = 1;
    wait_cyc(N - 1);
    chk(mode_o == 2'd0, "R2", "mode before wait ends", mode_o, 0);
    chk(!load_req && !cal_req, "R2", "request before wait ends", {load_req, cal_req}, 0);
    wait_cyc(N);
    chk(load_req == ms, "R3", "load_req after wait", load_req, ms);
    chk(cal_req == (!ms && ca), "R5", "cal_req after wait", cal_req, (!ms && ca));
    // R4: scramble pins after capture
    strap_ms = ~ms; strap_auto = ~au; strap_duty = ~du; strap_cal = ~ca;
    tt = N;
    if (ms) begin
      wait_cyc(tt + L);
      chk(load_req == 1'b1, "R3", "load_req held", load_req, 1);
      load_done = 1; @(negedge clk); load_done = 0;
      chk(load_req == 1'b0, "R3", "load_req after done", load_req, 0);
      tt += L + 1;
    end
    if (ca) begin
      wait_cyc(tt + C);
      chk(cal_req == 1'b1, "R5", "cal_req held", cal_req, 1);
      cal_done = 1; @(negedge clk); cal_done = 0;
      chk(cal_req == 1'b0, "R5", "cal_req after done", cal_req, 0);
      tt += C + 1;
      wait_cyc(tt + W - 1);
      chk(mode_o == 2'd0, "R5", "mode during settle wait", mode_o, 0);
      tt += W;
    end
    if (du == 3'b000) begin
      wait_cyc(tt + G);
      chk(mode_o == 2'd0, "R6", "mode while held for go", mode_o, 0);
      reg_go = 1; @(negedge clk); reg_go = 0;
      tt += G + 1;
    end
    wait_cyc(tt);
    chk(duty_init == du, "R4", "captured duty", duty_init, du);
    if (em == 3) begin
      chk(drive_en == 1'b0, "R9", "host drive_en with tx off", drive_en, 0);
      reg_tx_on = 1; #1;
      chk(drive_en == 1'b1, "R9", "host drive_en with tx on", drive_en, 1);
    end else
      chk(drive_en == 1'b1, "R8", "drive_en in self-run mode", drive_en, 1);
    @(negedge clk);
    chk(drive_start == 1'b0, "R8", "start pulse width", drive_start, 0);
    chk(int'(mode_o) == em, "R10", "mode held", mode_o, em);
    chk(expq.size() == 0, "R8", "missing drive_start", expq.size(), 0);
    if (em == 3) begin
      reg_tx_on = 0; #1;
      chk(drive_en == 1'b0, "R9", "host drive_en drops", drive_en, 0);
    end
  endtask

  task automatic finish_run;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    #(200000 * 5.0);
    chk(1'b0, "R2", "watchdog expired", 0, 1);
    finish_run();
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: standby state
    chk(mode_o == 2'd0 && !drive_en && !drive_start, "R1", "standby outputs",
        {mode_o, drive_en, drive_start}, 0);
    chk(!load_req && !cal_req, "R1", "standby requests", {load_req, cal_req}, 0);

    run_case(0, 0, 3'b010, 0, 0, 0, 0);   // stand-alone, no steps
    run_case(1, 1, 3'b000, 1, 5, 3, 4);   // auto, load+cal+hold
    run_case(0, 0, 3'b000, 0, 0, 0, 6);   // host-controlled, hold
    run_case(1, 0, 3'b100, 1, 2, 7, 0);   // stand-alone, load+cal
    run_case(0, 1, 3'b001, 1, 0, 2, 0);   // auto, cal only
    run_case(1, 0, 3'b000, 0, 3, 0, 2);   // host, load only

    // R1: standby in the middle of a load, then full restart
    stby_n = 0; strap_ms = 1; strap_auto = 0; strap_duty = 3'b011; strap_cal = 0;
    repeat (2) @(negedge clk);
    stby_n = 1;
    wait_cyc(N + 2);
    chk(load_req == 1'b1, "R3", "load pending before standby", load_req, 1);
    stby_n = 0; #1;
    chk(!load_req && mode_o == 2'd0 && !drive_en, "R1", "standby clears sequence",
        {load_req, mode_o, drive_en}, 0);
    run_case(1, 0, 3'b011, 0, 4, 0, 0);   // R1 restart from power-up wait

    finish_run();
  end
endmodule